// File: doc/BRIEF.md
# Eight-bit ALU with Masked Status Update

This block is the arithmetic and logic unit of a small 8-bit processor, together with the status byte that the processor's conditional jumps test. Each cycle the sequencer presents an opcode byte, the first operand, and two candidate second operands: a register value and an immediate byte. The opcode's low nibble chooses between them. The block returns the result and a write enable for the destination register in the same cycle. It updates the status byte on the rising clock edge.

Each operation class writes only its own group of flags, and every other flag keeps its value. Compare is unsigned. It records equality, "greater" and "less" in dedicated bits and never writes a destination. One status bit is not an ALU flag. It marks that a byte from the input port is held in the input register and has not yet been read. The input port alone drives that bit, and it keeps a held byte from being overwritten.

Top module: `alu_status_unit`

## Requirements
- R1: With `op_valid` high, a high nibble of 4, 5, 6 or 7 gives add, add with carry-in C, subtract, and subtract with borrow-in C. The 8-bit result appears on `result` with `dest_we` high in the same cycle.
- R2: Low nibble 0 takes the second operand from `opnd_reg`, and low nibble 1 takes it from `opnd_imm`. Any other low nibble, opcode B1, and any high nibble outside 4..C is a no-op: `dest_we` stays low and the status byte does not change.
- R3: The status byte `status` holds, from bit 7 to bit 0, C, V, Z, N, G, L, I and a constant 0. Reset clears the whole status byte and `in_byte`.
- R4: The four arithmetic operations update only C, V, Z and N. C is the unsigned carry out (add) or borrow (subtract), V is signed overflow, Z is set for a zero result, and N copies result bit 7.
- R5: AND (8), OR (9) and XOR (A) produce the bitwise result and update only Z and N.
- R6: Shift right (B0) shifts `opnd_s` right by one, with 0 entering bit 7 and bit 0 going to C. It updates only C, Z and N.
- R7: Compare (C) treats both operands as unsigned. Z marks equality, G marks first > second, and L marks first < second. It updates only Z, G and L and keeps `dest_we` low.
- R8: A pulse on `in_strobe` while I is 0 loads `in_data` into `in_byte` and sets I. ALU operations never change I.
- R9: While I is 1, `in_strobe` is ignored and `in_byte` keeps its value. A pulse on `in_read` clears I.
- R10: With `op_valid` low, `dest_we` is low and the flag bits C..L keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An ALU instruction is presented this cycle |
| opcode | input | 8 | Instruction byte |
| opnd_s | input | 8 | First operand |
| opnd_reg | input | 8 | Second operand, register form |
| opnd_imm | input | 8 | Second operand, immediate form |
| result | output | 8 | Operation result |
| dest_we | output | 1 | Write enable for the destination register |
| status | output | 8 | Status byte C V Z N G L I 0 |
| in_strobe | input | 1 | Input port offers a new byte |
| in_data | input | 8 | Byte offered by the input port |
| in_read | input | 1 | The processor reads the input register |
| in_byte | output | 8 | Input register contents |

## Verification
The hardest condition to produce is a flag that is not in the current operation's update group but holds a value that differs from its reset value. Only then can a wrongly widened mask be seen. The stimulus therefore sets G or L with a compare and sets C and V with an overflowing add before each logic, shift and compare step. It also issues ALU operations while a held input byte keeps I at 1. The simultaneous strobe-and-read cases are driven both with I at 0 and with I at 1.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    localparam int DATA_W = 8;
    localparam int NFLAG  = 6;

    typedef enum logic [3:0] {
        K_NONE = 4'd0,
        K_ADD  = 4'd1,
        K_ADC  = 4'd2,
        K_SUB  = 4'd3,
        K_SBB  = 4'd4,
        K_AND  = 4'd5,
        K_OR   = 4'd6,
        K_XOR  = 4'd7,
        K_SHR  = 4'd8,
        K_CMP  = 4'd9
    } alu_kind_e;

    // packed so that {flags, I, 1'b0} forms the status byte
    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
        logic g;
        logic l;
    } flags_t;

    typedef struct packed {
        logic      legal;
        alu_kind_e kind;
        logic      use_imm;
        logic      writes;
    } alu_ctrl_t;

    function automatic flags_t update_mask(alu_kind_e k);
        flags_t m;
        m = '0;
        case (k)
            K_ADD, K_ADC, K_SUB, K_SBB: begin
                m.c = 1'b1; m.v = 1'b1; m.z = 1'b1; m.n = 1'b1;
            end
            K_AND, K_OR, K_XOR: begin
                m.z = 1'b1; m.n = 1'b1;
            end
            K_SHR: begin
                m.c = 1'b1; m.z = 1'b1; m.n = 1'b1;
            end
            K_CMP: begin
                m.z = 1'b1; m.g = 1'b1; m.l = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic alu_ctrl_t decode_opcode(logic [7:0] opc);
        alu_ctrl_t c;
        logic      form_ok;
        c        = '0;
        c.kind   = K_NONE;
        form_ok  = (opc[3:0] == 4'h0) || (opc[3:0] == 4'h1);
        c.use_imm = opc[0];
        case (opc[7:4])
            4'h4: c.kind = K_ADD;
            4'h5: c.kind = K_ADC;
            4'h6: c.kind = K_SUB;
            4'h7: c.kind = K_SBB;
            4'h8: c.kind = K_AND;
            4'h9: c.kind = K_OR;
            4'hA: c.kind = K_XOR;
            4'hB: c.kind = K_SHR;
            4'hC: c.kind = K_CMP;
            default: c.kind = K_NONE;
        endcase
        if (c.kind == K_SHR) begin
            form_ok = (opc[3:0] == 4'h0);
        end
        c.legal  = form_ok && (c.kind != K_NONE);
        c.writes = c.legal && (c.kind != K_CMP);
        return c;
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_status_pkg::*;
(
    input  logic       op_valid,
    input  logic [7:0] opcode,
    output alu_ctrl_t  ctrl
);
    alu_ctrl_t raw;

    always_comb begin
        raw          = decode_opcode(opcode);
        ctrl         = raw;
        ctrl.legal   = raw.legal && op_valid;
        ctrl.writes  = raw.writes && op_valid;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_status_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_kind_e      kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output flags_t         fl
);
    logic [W:0] wide;
    logic       cy;

    always_comb begin
        wide = '0;
        res  = '0;
        fl   = '0;
        cy   = 1'b0;
        case (kind)
            K_ADD, K_ADC: begin
                cy   = (kind == K_ADC) ? c_in : 1'b0;
                wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cy};
                res  = wide[W-1:0];
                fl.c = wide[W];
                fl.v = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
            end
            K_SUB, K_SBB: begin
                cy   = (kind == K_SBB) ? c_in : 1'b0;
                wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cy};
                res  = wide[W-1:0];
                fl.c = wide[W];
                fl.v = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
            end
            K_AND: res = a & b;
            K_OR:  res = a | b;
            K_XOR: res = a ^ b;
            K_SHR: begin
                res  = {1'b0, a[W-1:1]};
                fl.c = a[0];
            end
            K_CMP: begin
                res  = '0;
                fl.g = (a > b);
                fl.l = (a < b);
            end
            default: res = '0;
        endcase
        fl.n = res[W-1];
        fl.z = (kind == K_CMP) ? (a == b) : (res == '0);
    end
endmodule

// File: rtl/alu_input_latch.sv
module alu_input_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_strobe,
    input  logic [W-1:0] in_data,
    input  logic         in_read,
    output logic [W-1:0] in_byte,
    output logic         pending
);
    logic take;

    assign take = in_strobe && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_byte <= '0;
            pending <= 1'b0;
        end else begin
            if (take) begin
                in_byte <= in_data;
            end
            pending <= (pending && !in_read) || take;
        end
    end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [7:0] opcode,
    input  logic [7:0] opnd_s,
    input  logic [7:0] opnd_reg,
    input  logic [7:0] opnd_imm,
    output logic [7:0] result,
    output logic       dest_we,
    output logic [7:0] status,
    input  logic       in_strobe,
    input  logic [7:0] in_data,
    input  logic       in_read,
    output logic [7:0] in_byte
);
    alu_ctrl_t          ctrl;
    logic [DATA_W-1:0]  opnd_t;
    flags_t             flags_q;
    flags_t             flags_calc;
    flags_t             mask;
    logic [NFLAG-1:0]   flags_d;
    logic               pend;

    alu_decode u_dec (
        .op_valid (op_valid),
        .opcode   (opcode),
        .ctrl     (ctrl)
    );

    assign opnd_t = ctrl.use_imm ? opnd_imm : opnd_reg;

    alu_core #(.W(DATA_W)) u_core (
        .kind (ctrl.kind),
        .a    (opnd_s),
        .b    (opnd_t),
        .c_in (flags_q.c),
        .res  (result),
        .fl   (flags_calc)
    );

    alu_input_latch #(.W(DATA_W)) u_inp (
        .clk       (clk),
        .rst       (rst),
        .in_strobe (in_strobe),
        .in_data   (in_data),
        .in_read   (in_read),
        .in_byte   (in_byte),
        .pending   (pend)
    );

    assign mask    = ctrl.legal ? update_mask(ctrl.kind) : '0;
    assign dest_we = ctrl.writes;

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        assign flags_d[k] = mask[k] ? flags_calc[k] : flags_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_t'(flags_d);
        end
    end

    assign status = {flags_q, pend, 1'b0};
endmodule

// File: rtl/alu_status_checker.sv
module alu_status_checker (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [7:0] opcode,
    input logic       dest_we,
    input logic [7:0] status,
    input logic       in_strobe,
    input logic       in_read,
    input logic [7:0] in_byte
);
    p_spare_bit_zero_r3: assert property (@(posedge clk) disable iff (rst)
        status[0] == 1'b0);

    p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode[7:4] == 4'hC) |-> !dest_we);

    p_gl_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(status[3] && status[2]));

    p_alu_keeps_i_r8: assert property (@(posedge clk) disable iff (rst)
        (!in_strobe && !in_read) |=> status[1] == $past(status[1]));

    p_held_byte_stable_r9: assert property (@(posedge clk) disable iff (rst)
        status[1] |=> $stable(in_byte));

    p_read_clears_i_r9: assert property (@(posedge clk) disable iff (rst)
        (status[1] && in_read) |=> !status[1]);

    p_idle_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !dest_we);

    p_idle_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> status[7:2] == $past(status[7:2]));

    p_logic_keeps_cvgl_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (opcode == 8'h80 || opcode == 8'h81 || opcode == 8'h90 ||
                      opcode == 8'h91 || opcode == 8'hA0 || opcode == 8'hA1))
        |=> (status[7:6] == $past(status[7:6]) && status[3:2] == $past(status[3:2])));
endmodule

bind alu_status_unit alu_status_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .dest_we   (dest_we),
    .status    (status),
    .in_strobe (in_strobe),
    .in_read   (in_read),
    .in_byte   (in_byte)
);

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
    localparam time PERIOD = 8ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = '0;
    logic [7:0] opnd_s = '0;
    logic [7:0] opnd_reg = '0;
    logic [7:0] opnd_imm = '0;
    logic [7:0] result;
    logic       dest_we;
    logic [7:0] status;
    logic       in_strobe = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_read = 1'b0;
    logic [7:0] in_byte;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // bench model of the flags, following the requirements
    logic m_c, m_v, m_z, m_n, m_g, m_l, m_i;
    logic [7:0] m_in;

    always #(PERIOD/2) clk = ~clk;

    alu_status_unit i_alu_status_unit (
        .clk (clk), .rst (rst), .op_valid (op_valid), .opcode (opcode),
        .opnd_s (opnd_s), .opnd_reg (opnd_reg), .opnd_imm (opnd_imm),
        .result (result), .dest_we (dest_we), .status (status),
        .in_strobe (in_strobe), .in_data (in_data), .in_read (in_read),
        .in_byte (in_byte)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_status();
        return {m_c, m_v, m_z, m_n, m_g, m_l, m_i, 1'b0};
    endfunction

    // one ALU instruction, with checks of result, write enable and status
    task automatic do_op(string req, logic [7:0] opc, logic [7:0] s, logic [7:0] r, logic [7:0] imm);
        logic [3:0] hi;
        logic       legal;
        logic [7:0] t, er;
        int         w;
        hi    = opc[7:4];
        legal = (hi >= 4'h4 && hi <= 4'hC) &&
                ((opc[3:0] == 4'h0) || (opc[3:0] == 4'h1 && hi != 4'hB));
        t     = opc[0] ? imm : r;
        er    = '0;
        @(negedge clk);
        op_valid = 1'b1; opcode = opc; opnd_s = s; opnd_reg = r; opnd_imm = imm;
        #1;
        if (legal) begin
            case (hi)
                4'h4, 4'h5: begin
                    w = int'(s) + int'(t) + ((hi == 4'h5) ? int'(m_c) : 0);
                    er = w[7:0];
                    m_c = (w > 255);
                    m_v = (s[7] == t[7]) && (er[7] != s[7]);
                end
                4'h6, 4'h7: begin
                    w = int'(s) - int'(t) - ((hi == 4'h7) ? int'(m_c) : 0);
                    er = w[7:0];
                    m_c = (w < 0);
                    m_v = (s[7] != t[7]) && (er[7] != s[7]);
                end
                4'h8: er = s & t;
                4'h9: er = s | t;
                4'hA: er = s ^ t;
                4'hB: begin er = s >> 1; m_c = s[0]; end
                default: begin
                    m_g = (s > t); m_l = (s < t); m_z = (s == t);
                end
            endcase
            if (hi != 4'hC) begin
                m_z = (er == 8'h00);
                m_n = er[7];
                chk(req, "result", {8'h0, result}, {8'h0, er});
            end
        end
        chk(req, "dest_we", {15'h0, dest_we}, {15'h0, legal && hi != 4'hC});
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        chk(req, "status", {8'h0, status}, {8'h0, model_status()});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        {m_c, m_v, m_z, m_n, m_g, m_l, m_i} = '0;
        m_in = '0;
        chk("R3", "status after reset", {8'h0, status}, 16'h0000);
        chk("R3", "in_byte after reset", {8'h0, in_byte}, 16'h0000);
        chk("R10", "dest_we idle", {15'h0, dest_we}, 16'h0000);
    endtask

    task automatic t_arith();
        do_op("R4", 8'h40, 8'h7F, 8'h01, 8'hEE);   // signed overflow, N
        chk("R4", "V after 7F+01", {15'h0, status[6]}, 16'h1);
        do_op("R2", 8'h41, 8'hFF, 8'h55, 8'h01);   // immediate form, carry, zero
        chk("R4", "C,Z after FF+01", {14'h0, status[7], status[5]}, 16'h3);
        do_op("R1", 8'h50, 8'h10, 8'h20, 8'h00);   // adc with C=1 -> 31
        do_op("R1", 8'h60, 8'h00, 8'h01, 8'h00);   // borrow
        chk("R4", "borrow 00-01", {15'h0, status[7]}, 16'h1);
        do_op("R1", 8'h71, 8'h10, 8'h00, 8'h05);   // sbb with C=1 -> 0A
        do_op("R4", 8'h60, 8'h80, 8'h01, 8'h00);   // signed overflow on sub
        do_op("R1", 8'h70, 8'h00, 8'hFF, 8'h00);   // sbb borrow chain
    endtask

    task automatic t_logic();
        do_op("R4", 8'h40, 8'h80, 8'h80, 8'h00);   // set C and V
        do_op("R7", 8'hC1, 8'h09, 8'h00, 8'h03);   // set G
        do_op("R5", 8'h80, 8'hF0, 8'h0F, 8'h00);   // zero result
        do_op("R5", 8'h91, 8'h81, 8'h00, 8'h02);
        do_op("R5", 8'hA0, 8'hFF, 8'h0F, 8'h00);
        chk("R5", "C,V,G kept", {13'h0, status[7], status[6], status[3]}, 16'h7);
    endtask

    task automatic t_shift();
        do_op("R7", 8'hC0, 8'h01, 8'h02, 8'h00);   // set L
        do_op("R6", 8'hB0, 8'h81, 8'hAA, 8'hBB);   // -> 40, C=1
        do_op("R6", 8'hB0, 8'h01, 8'h00, 8'h00);   // -> 00, C=1, Z
        do_op("R6", 8'hB0, 8'h02, 8'hFF, 8'hFF);   // -> 01, C=0
        chk("R6", "L kept", {15'h0, status[2]}, 16'h1);
        do_op("R2", 8'hB1, 8'h81, 8'h00, 8'h00);   // illegal form
    endtask

    task automatic t_compare();
        do_op("R4", 8'h41, 8'h7F, 8'h00, 8'h01);   // C=0 V=1 N=1
        do_op("R7", 8'hC0, 8'h05, 8'h03, 8'h00);
        do_op("R7", 8'hC1, 8'h03, 8'h00, 8'h05);
        do_op("R7", 8'hC0, 8'h07, 8'h07, 8'h00);
        do_op("R7", 8'hC1, 8'h80, 8'h00, 8'h01);   // unsigned: 80 > 01
        chk("R7", "V,N kept", {14'h0, status[6], status[4]}, 16'h3);
    endtask

    task automatic t_illegal();
        do_op("R2", 8'h42, 8'h01, 8'h01, 8'h01);
        do_op("R2", 8'h10, 8'h01, 8'h01, 8'h01);
        do_op("R2", 8'hD0, 8'h01, 8'h01, 8'h01);
        do_op("R2", 8'h8F, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        opcode = 8'h60; opnd_s = 8'h00; opnd_reg = 8'h05; op_valid = 1'b0;
        #1;
        chk("R10", "dest_we with op_valid low", {15'h0, dest_we}, 16'h0);
        @(posedge clk);
        #1;
        chk("R10", "status with op_valid low", {8'h0, status}, {8'h0, model_status()});
    endtask

    task automatic input_cycle(logic stb, logic [7:0] d, logic rd);
        logic take;
        @(negedge clk);
        in_strobe = stb; in_data = d; in_read = rd;
        take = stb && !m_i;
        if (take) m_in = d;
        m_i = (m_i && !rd) || take;
        @(posedge clk);
        #1;
        in_strobe = 1'b0; in_read = 1'b0;
    endtask

    task automatic t_input();
        input_cycle(1'b1, 8'hA5, 1'b0);
        chk("R8", "I set", {15'h0, status[1]}, 16'h1);
        chk("R8", "byte latched", {8'h0, in_byte}, 16'h00A5);
        input_cycle(1'b1, 8'h3C, 1'b0);
        chk("R9", "byte kept while I=1", {8'h0, in_byte}, 16'h00A5);
        do_op("R8", 8'h60, 8'h00, 8'h00, 8'h00);
        chk("R8", "I kept by ALU", {15'h0, status[1]}, 16'h1);
        input_cycle(1'b1, 8'h77, 1'b1);            // I=1: read wins, byte kept
        chk("R9", "I cleared by read", {15'h0, status[1]}, 16'h0);
        chk("R9", "byte kept on read", {8'h0, in_byte}, 16'h00A5);
        input_cycle(1'b1, 8'h5A, 1'b1);            // I=0: strobe loads
        chk("R8", "I set on strobe+read", {15'h0, status[1]}, 16'h1);
        chk("R8", "byte loaded", {8'h0, in_byte}, 16'h005A);
        do_op("R8", 8'h41, 8'hFF, 8'h00, 8'h01);
        input_cycle(1'b0, 8'h00, 1'b1);
        chk("R9", "I cleared", {8'h0, status}, {8'h0, model_status()});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_shift();
        t_compare();
        t_illegal();
        t_input();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule